// File: doc/BRIEF.md
# USB Device Endpoint Handshake Responder

This block chooses the handshake a USB device endpoint returns to a host token without firmware stepping in on each transaction. A decoded token event (kind, endpoint number and, for OUT, the received payload length) is matched against the endpoint set: one control endpoint at number 0 and five general endpoints. Each general endpoint has its own number, direction and enable. The chosen endpoint's FIFO fill level and free space, compared with its maximum packet size, decide whether the reply is DATA, NAK, ACK or NYET.

The same block keeps the bus speed chosen at the last bus reset, since PING and NYET flow control exist only at high speed. It tells the FIFO when to keep a received OUT packet. It also tells the FIFO when to move the read pointer past a sent IN packet, or to return it to the packet start. The data path, CRC, toggle checking and line signalling are outside this block.

Top module: `usb_ep_handshake`

## Requirements
- R1: Endpoint slot 0 matches any token kind addressed to endpoint number 0 when its enable is set. General slot i (1 to 5) matches when enabled, when its number equals the token's endpoint, and when its direction fits the token: an IN token needs direction IN (1), OUT and PING need direction OUT (0). If several slots match, the lowest slot wins. An unmatched token gets response code NONE.
- R2: An IN token answers DATA when the slot's fill count is at least its maximum packet size, and NAK otherwise.
- R3: At high speed a PING answers ACK when free space is at least the maximum packet size, and NAK otherwise. At full speed a PING answers NONE.
- R4: An OUT packet answers NAK when free space is below the maximum packet size or below the packet length. Otherwise it answers ACK, except at high speed when free space minus length drops below the maximum packet size, which answers NYET. Full speed never answers NYET.
- R5: The commit pulse occurs with the response, and only for an OUT answered ACK or NYET.
- R6: After a DATA reply the block waits for the host. A host ACK gives one rd_advance pulse one cycle later, carrying the slot index. A host timeout gives one rd_rewind pulse instead.
- R7: A token that arrives while a DATA reply still waits for the host rewinds that slot in the same cycle as the new token's response. The new token is answered normally.
- R8: Speed resets to full speed (hs_mode 0). On a bus-reset-done pulse, hs_mode becomes 1 exactly when the peer is high-speed capable and force_fs is 0. At all other times it holds.
- R9: Every response appears one cycle after its token. In reset all outputs are 0.
- R10: A host ACK or timeout that arrives while no DATA reply is pending has no effect.
- R11: Token kind encoding is OUT=0, IN=1, PING=2. Kind 3 answers NONE. Response codes are NONE=0, DATA=1, NAK=2, ACK=3, NYET=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| force_fs | input | 1 | Keep full speed at the next bus reset |
| peer_hs | input | 1 | Host completed high-speed handshake during bus reset |
| bus_rst_done | input | 1 | Pulse at the end of a bus reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind (OUT=0, IN=1, PING=2) |
| tok_ep | input | 4 | Token endpoint number |
| rx_len | input | CNT_W | Received OUT payload length in bytes |
| host_ack | input | 1 | Host ACK to a DATA reply |
| host_timeout | input | 1 | No valid host handshake after a DATA reply |
| cfg_en | input | NUM_EP | Per-slot enable |
| cfg_dir_in | input | NUM_EP-1 | General slot direction, 1 = IN |
| cfg_epnum | input | (NUM_EP-1)*4 | General slot endpoint numbers |
| cfg_mps | input | NUM_EP*MPS_W | Per-slot maximum packet size |
| fifo_count | input | NUM_EP*CNT_W | Per-slot bytes held |
| fifo_free | input | NUM_EP*CNT_W | Per-slot free bytes |
| hs_mode | output | 1 | 1 = high speed |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 3 | Response code |
| resp_idx | output | IDX_W | Slot answering |
| commit | output | 1 | Keep the received OUT packet |
| rd_advance | output | 1 | Move the read pointer past the sent packet |
| rd_rewind | output | 1 | Return the read pointer to the packet start |
| rd_idx | output | IDX_W | Slot of the pointer action |

## Verification
The assertions check on every cycle that commit only comes with an ACK or NYET response, and that NYET never comes at full speed. They also check that a full-speed PING stays silent, that a response always follows a token, that the read pointer never advances and rewinds together, and that the speed flag holds between bus resets. Only the bench's scenarios can show the FIFO thresholds themselves: the boundary at exactly the maximum packet size, the endpoint priority and direction rules, and the pairing of a pending DATA reply with a later ACK, timeout or new token. The bench checks these against a behavioural model on every clock.

// File: rtl/uhr_pkg.sv
package uhr_pkg;
    localparam int EPN_W = 4;

    typedef enum logic [1:0] {
        TK_OUT  = 2'd0,
        TK_IN   = 2'd1,
        TK_PING = 2'd2,
        TK_RSVD = 2'd3
    } tok_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_DATA = 3'd1,
        RSP_NAK  = 3'd2,
        RSP_ACK  = 3'd3,
        RSP_NYET = 3'd4
    } rsp_e;
endpackage

// File: rtl/uhr_speed.sv
module uhr_speed (
    input  logic clk,
    input  logic rst_n,
    input  logic force_fs,
    input  logic peer_hs,
    input  logic bus_rst_done,
    output logic hs_q
);
    logic hs_d;

    always_comb begin
        hs_d = hs_q;
        if (bus_rst_done) begin
            hs_d = peer_hs && !force_fs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= hs_d;
    end

    // R8: a forced full-speed negotiation never yields high speed
    p_force_fs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_done && force_fs) |=> !hs_q);
    // R8: speed holds between bus resets
    p_speed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_done |=> $stable(hs_q));
endmodule

// File: rtl/uhr_match.sv
module uhr_match
    import uhr_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int CNT_W  = 13,
    parameter int MPS_W  = 11,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic [1:0]                   tok_kind,
    input  logic [EPN_W-1:0]             tok_ep,
    input  logic [NUM_EP-1:0]            cfg_en,
    input  logic [NUM_EP-2:0]            cfg_dir_in,
    input  logic [(NUM_EP-1)*EPN_W-1:0]  cfg_epnum,
    input  logic [NUM_EP*MPS_W-1:0]      cfg_mps,
    input  logic [NUM_EP*CNT_W-1:0]      fifo_count,
    input  logic [NUM_EP*CNT_W-1:0]      fifo_free,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx,
    output logic [MPS_W-1:0]             mps,
    output logic [CNT_W-1:0]             count,
    output logic [CNT_W-1:0]             free
);
    logic [NUM_EP-1:0] hit_v;
    logic              want_in;

    assign want_in = (tok_kind == TK_IN);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
        if (i == 0) begin : g_ctrl
            assign hit_v[i] = cfg_en[i] && (tok_ep == '0);
        end else begin : g_gen
            logic [EPN_W-1:0] num;
            assign num      = cfg_epnum[(i-1)*EPN_W +: EPN_W];
            assign hit_v[i] = cfg_en[i] && (num == tok_ep) &&
                              (cfg_dir_in[i-1] == want_in);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if (hit_v[i]) idx = IDX_W'(i);
        end
        hit   = |hit_v;
        mps   = cfg_mps[idx*MPS_W +: MPS_W];
        count = fifo_count[idx*CNT_W +: CNT_W];
        free  = fifo_free[idx*CNT_W +: CNT_W];
    end
endmodule

// File: rtl/uhr_decide.sv
module uhr_decide
    import uhr_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int MPS_W = 11
) (
    input  logic             hit,
    input  logic [1:0]       tok_kind,
    input  logic             hs,
    input  logic [MPS_W-1:0] mps,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] free,
    input  logic [CNT_W-1:0] rx_len,
    output rsp_e             code,
    output logic             keep
);
    logic [CNT_W-1:0] mps_w;
    logic             room_pkt;
    logic             room_len;
    logic [CNT_W-1:0] left;

    assign mps_w    = CNT_W'(mps);
    assign room_pkt = (free >= mps_w);
    assign room_len = (free >= rx_len);
    assign left     = free - rx_len;

    always_comb begin
        code = RSP_NONE;
        keep = 1'b0;
        if (hit) begin
            unique case (tok_kind)
                TK_IN:   code = (count >= mps_w) ? RSP_DATA : RSP_NAK;
                TK_PING: begin
                    if (hs) code = room_pkt ? RSP_ACK : RSP_NAK;
                end
                TK_OUT: begin
                    if (!room_pkt || !room_len) begin
                        code = RSP_NAK;
                    end else begin
                        keep = 1'b1;
                        code = (hs && (left < mps_w)) ? RSP_NYET : RSP_ACK;
                    end
                end
                default: code = RSP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import uhr_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int CNT_W  = 13,
    parameter int MPS_W  = 11,
    localparam int IDX_W = $clog2(NUM_EP)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         force_fs,
    input  logic                         peer_hs,
    input  logic                         bus_rst_done,
    input  logic                         tok_valid,
    input  logic [1:0]                   tok_kind,
    input  logic [EPN_W-1:0]             tok_ep,
    input  logic [CNT_W-1:0]             rx_len,
    input  logic                         host_ack,
    input  logic                         host_timeout,
    input  logic [NUM_EP-1:0]            cfg_en,
    input  logic [NUM_EP-2:0]            cfg_dir_in,
    input  logic [(NUM_EP-1)*EPN_W-1:0]  cfg_epnum,
    input  logic [NUM_EP*MPS_W-1:0]      cfg_mps,
    input  logic [NUM_EP*CNT_W-1:0]      fifo_count,
    input  logic [NUM_EP*CNT_W-1:0]      fifo_free,
    output logic                         hs_mode,
    output logic                         resp_valid,
    output logic [2:0]                   resp_code,
    output logic [IDX_W-1:0]             resp_idx,
    output logic                         commit,
    output logic                         rd_advance,
    output logic                         rd_rewind,
    output logic [IDX_W-1:0]             rd_idx
);
    typedef struct packed {
        logic             rv;
        rsp_e             code;
        logic [IDX_W-1:0] ridx;
        logic             keep;
        logic             pend;
        logic [IDX_W-1:0] pidx;
        logic             adv;
        logic             rew;
        logic [IDX_W-1:0] pptr;
    } st_t;

    st_t st_d, st_q;

    logic             hs_q;
    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic [MPS_W-1:0] m_mps;
    logic [CNT_W-1:0] m_count;
    logic [CNT_W-1:0] m_free;
    rsp_e             dec_code;
    logic             dec_keep;

    uhr_speed u_speed (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_fs     (force_fs),
        .peer_hs      (peer_hs),
        .bus_rst_done (bus_rst_done),
        .hs_q         (hs_q)
    );

    uhr_match #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .MPS_W(MPS_W)) u_match (
        .tok_kind   (tok_kind),
        .tok_ep     (tok_ep),
        .cfg_en     (cfg_en),
        .cfg_dir_in (cfg_dir_in),
        .cfg_epnum  (cfg_epnum),
        .cfg_mps    (cfg_mps),
        .fifo_count (fifo_count),
        .fifo_free  (fifo_free),
        .hit        (m_hit),
        .idx        (m_idx),
        .mps        (m_mps),
        .count      (m_count),
        .free       (m_free)
    );

    uhr_decide #(.CNT_W(CNT_W), .MPS_W(MPS_W)) u_decide (
        .hit      (m_hit),
        .tok_kind (tok_kind),
        .hs       (hs_q),
        .mps      (m_mps),
        .count    (m_count),
        .free     (m_free),
        .rx_len   (rx_len),
        .code     (dec_code),
        .keep     (dec_keep)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.code = RSP_NONE;
        st_d.ridx = '0;
        st_d.keep = 1'b0;
        st_d.adv  = 1'b0;
        st_d.rew  = 1'b0;
        st_d.pptr = '0;

        if (st_q.pend) begin
            if (host_ack) begin
                st_d.adv  = 1'b1;
                st_d.pptr = st_q.pidx;
                st_d.pend = 1'b0;
            end else if (host_timeout || tok_valid) begin
                st_d.rew  = 1'b1;
                st_d.pptr = st_q.pidx;
                st_d.pend = 1'b0;
            end
        end

        if (tok_valid) begin
            st_d.rv   = 1'b1;
            st_d.code = dec_code;
            st_d.ridx = m_hit ? m_idx : '0;
            st_d.keep = dec_keep;
            if (dec_code == RSP_DATA) begin
                st_d.pend = 1'b1;
                st_d.pidx = m_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_mode    = hs_q;
    assign resp_valid = st_q.rv;
    assign resp_code  = st_q.code;
    assign resp_idx   = st_q.ridx;
    assign commit     = st_q.keep;
    assign rd_advance = st_q.adv;
    assign rd_rewind  = st_q.rew;
    assign rd_idx     = st_q.pptr;

    // R5: commit only alongside an accepting answer
    p_commit_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (resp_valid && (resp_code == RSP_ACK || resp_code == RSP_NYET)));
    // R4: NYET only when the decision was taken at high speed
    p_nyet_hs_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RSP_NYET) |-> $past(hs_mode));
    // R3: full-speed PING gets no handshake
    p_fs_ping_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TK_PING && !hs_mode) |=> (resp_code == RSP_NONE));
    // R9: a response always follows a token by one cycle
    p_resp_after_tok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(tok_valid));
    // R6: pointer never advances and rewinds together
    p_one_ptr_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_advance && rd_rewind));
    // R6: advance only after a host ACK
    p_adv_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_advance |-> $past(host_ack));
endmodule

// File: tb/usb_ep_handshake_tb.sv
module usb_ep_handshake_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP = 6;
    localparam int CNT_W  = 13;
    localparam int MPS_W  = 11;
    localparam int IDX_W  = $clog2(NUM_EP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_fs = 0, peer_hs = 0, bus_rst_done = 0;
    logic tok_valid = 0;
    logic [1:0] tok_kind = 0;
    logic [3:0] tok_ep = 0;
    logic [CNT_W-1:0] rx_len = 0;
    logic host_ack = 0, host_timeout = 0;
    logic [NUM_EP-1:0] cfg_en = 0;
    logic [NUM_EP-2:0] cfg_dir_in = 0;
    logic [(NUM_EP-1)*4-1:0] cfg_epnum = 0;
    logic [NUM_EP*MPS_W-1:0] cfg_mps = 0;
    logic [NUM_EP*CNT_W-1:0] fifo_count = 0, fifo_free = 0;
    logic hs_mode, resp_valid, commit, rd_advance, rd_rewind;
    logic [2:0] resp_code;
    logic [IDX_W-1:0] resp_idx, rd_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ep_handshake #(.NUM_EP(NUM_EP), .CNT_W(CNT_W), .MPS_W(MPS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .force_fs(force_fs), .peer_hs(peer_hs),
        .bus_rst_done(bus_rst_done), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_ep(tok_ep), .rx_len(rx_len), .host_ack(host_ack),
        .host_timeout(host_timeout), .cfg_en(cfg_en), .cfg_dir_in(cfg_dir_in),
        .cfg_epnum(cfg_epnum), .cfg_mps(cfg_mps), .fifo_count(fifo_count),
        .fifo_free(fifo_free), .hs_mode(hs_mode), .resp_valid(resp_valid),
        .resp_code(resp_code), .resp_idx(resp_idx), .commit(commit),
        .rd_advance(rd_advance), .rd_rewind(rd_rewind), .rd_idx(rd_idx)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    string cur_req = "R9";

    int m_num[NUM_EP], m_mps[NUM_EP], m_cnt[NUM_EP], m_free[NUM_EP];
    bit m_en[NUM_EP], m_dir[NUM_EP];
    bit m_hs = 0, m_wait = 0;
    int m_widx = 0;

    task automatic set_ep(int i, int num, int mps, bit dir_in, bit en);
        m_num[i] = num; m_mps[i] = mps; m_dir[i] = dir_in; m_en[i] = en;
        cfg_en[i] = en;
        cfg_mps[i*MPS_W +: MPS_W] = MPS_W'(mps);
        if (i > 0) begin
            cfg_epnum[(i-1)*4 +: 4] = 4'(num);
            cfg_dir_in[i-1] = dir_in;
        end
    endtask

    task automatic set_fifo(int i, int cnt, int fr);
        m_cnt[i] = cnt; m_free[i] = fr;
        fifo_count[i*CNT_W +: CNT_W] = CNT_W'(cnt);
        fifo_free[i*CNT_W +: CNT_W]  = CNT_W'(fr);
    endtask

    // reference: compute expected, step one clock, compare
    task automatic tick();
        bit e_hs, e_rv, e_keep, e_adv, e_rew, nw;
        int e_code, e_ridx, e_ptr, nwidx, sel;
        e_hs = bus_rst_done ? (peer_hs && !force_fs) : m_hs;
        e_rv = 0; e_keep = 0; e_adv = 0; e_rew = 0; e_code = 0; e_ridx = 0; e_ptr = 0;
        nw = m_wait; nwidx = m_widx;
        if (m_wait) begin
            if (host_ack) begin e_adv = 1; e_ptr = m_widx; nw = 0; end
            else if (host_timeout || tok_valid) begin e_rew = 1; e_ptr = m_widx; nw = 0; end
        end
        if (tok_valid) begin
            e_rv = 1;
            sel = -1;
            for (int i = 0; i < NUM_EP; i++) begin
                bit ok;
                if (i == 0) ok = m_en[0] && tok_ep == 0;
                else ok = m_en[i] && m_num[i] == int'(tok_ep) && (m_dir[i] == (tok_kind == 2'd1));
                if (ok && sel < 0) sel = i;
            end
            if (sel >= 0 && tok_kind != 2'd3) begin
                e_ridx = sel;
                if (tok_kind == 2'd1) e_code = (m_cnt[sel] >= m_mps[sel]) ? 1 : 2;
                else if (tok_kind == 2'd2) begin
                    if (m_hs) e_code = (m_free[sel] >= m_mps[sel]) ? 3 : 2;
                end else begin
                    if (m_free[sel] < m_mps[sel] || m_free[sel] < int'(rx_len)) e_code = 2;
                    else begin
                        e_keep = 1;
                        e_code = (m_hs && (m_free[sel] - int'(rx_len)) < m_mps[sel]) ? 4 : 3;
                    end
                end
                if (e_code == 1) begin nw = 1; nwidx = sel; end
            end else if (sel >= 0) e_ridx = sel;
        end
        @(posedge clk);
        #1;
        n_checks++;
        if (hs_mode !== e_hs || resp_valid !== e_rv || int'(resp_code) != e_code ||
            (e_rv && int'(resp_idx) != e_ridx) || commit !== e_keep ||
            rd_advance !== e_adv || rd_rewind !== e_rew ||
            ((e_adv || e_rew) && int'(rd_idx) != e_ptr)) begin
            n_fail++;
            $display("FAIL %s: actual hs=%0b v=%0b code=%0d idx=%0d keep=%0b adv=%0b rew=%0b ptr=%0d expected hs=%0b v=%0b code=%0d idx=%0d keep=%0b adv=%0b rew=%0b ptr=%0d",
                     cur_req, hs_mode, resp_valid, resp_code, resp_idx, commit, rd_advance,
                     rd_rewind, rd_idx, e_hs, e_rv, e_code, e_ridx, e_keep, e_adv, e_rew, e_ptr);
        end
        m_hs = e_hs; m_wait = nw; m_widx = nwidx;
    endtask

    task automatic tok(string req, int kind, int ep, int len);
        cur_req = req;
        tok_valid = 1; tok_kind = 2'(kind); tok_ep = 4'(ep); rx_len = CNT_W'(len);
        tick();
        tok_valid = 0;
        tick();
    endtask

    task automatic host(string req, bit ack, bit tmo);
        cur_req = req;
        host_ack = ack; host_timeout = tmo;
        tick();
        host_ack = 0; host_timeout = 0;
        tick();
    endtask

    task automatic bus_reset(string req, bit phs, bit ffs);
        cur_req = req;
        peer_hs = phs; force_fs = ffs; bus_rst_done = 1;
        tick();
        bus_rst_done = 0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_EP; i++) begin
            m_num[i] = 0; m_mps[i] = 0; m_cnt[i] = 0; m_free[i] = 0; m_en[i] = 0; m_dir[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        n_checks++;
        if (hs_mode || resp_valid || resp_code != 0 || commit || rd_advance || rd_rewind) begin
            n_fail++;
            $display("FAIL R9: actual nonzero outputs in reset expected all 0");
        end
        set_ep(0, 0, 64, 0, 1);
        set_ep(1, 1, 64, 1, 1);
        set_ep(2, 2, 64, 0, 1);
        set_ep(3, 5, 512, 1, 1);
        set_ep(4, 2, 64, 1, 1);
        set_ep(5, 7, 64, 0, 0);
        for (int i = 0; i < NUM_EP; i++) set_fifo(i, 0, 1000);
        rst_n = 1;
        cur_req = "R9";
        tick();

        // full speed
        set_fifo(1, 64, 0);   tok("R2", 1, 1, 0);
        host("R6", 1, 0);
        set_fifo(1, 63, 0);   tok("R2", 1, 1, 0);
        set_fifo(2, 0, 64);   tok("R4", 0, 2, 64);
        set_fifo(2, 0, 63);   tok("R4", 0, 2, 10);
        set_fifo(2, 0, 64);   tok("R3", 2, 2, 0);
        tok("R5", 0, 2, 64);
        // speed negotiation
        bus_reset("R8", 1, 1);
        bus_reset("R8", 0, 0);
        bus_reset("R8", 1, 0);
        // high speed
        set_fifo(2, 0, 64);  tok("R3", 2, 2, 0);
        set_fifo(2, 0, 63);  tok("R3", 2, 2, 0);
        set_fifo(2, 0, 100); tok("R4", 0, 2, 64);
        set_fifo(2, 0, 200); tok("R4", 0, 2, 64);
        set_fifo(2, 0, 64);  tok("R4", 0, 2, 65);
        set_fifo(2, 0, 128); tok("R5", 0, 2, 64);
        // IN boundary and host outcomes
        set_fifo(3, 511, 0); tok("R2", 1, 5, 0);
        set_fifo(3, 512, 0); tok("R2", 1, 5, 0);
        host("R6", 0, 1);
        host("R10", 1, 0);
        host("R10", 0, 1);
        // token while a DATA reply waits
        cur_req = "R7";
        tok_valid = 1; tok_kind = 2'd1; tok_ep = 4'd5; tick();
        tok_kind = 2'd1; tok_ep = 4'd1; set_fifo(1, 64, 0); tick();
        tok_valid = 0; tick();
        host("R6", 1, 0);
        // matching rules
        set_fifo(4, 64, 0); tok("R1", 1, 2, 0);
        tok("R1", 0, 1, 8);
        tok("R1", 0, 7, 8);
        tok("R1", 1, 9, 0);
        set_fifo(0, 64, 64); tok("R1", 1, 0, 0);
        host("R6", 1, 0);
        tok("R1", 0, 0, 8);
        tok("R11", 3, 2, 0);
        set_ep(4, 1, 64, 1, 1); tok("R1", 1, 1, 0);
        host("R6", 0, 1);

        // mixed traffic against the model
        cur_req = "R4";
        for (int n = 0; n < 600; n++) begin
            tok_valid = ($urandom_range(0, 2) != 0);
            tok_kind = 2'($urandom_range(0, 3));
            tok_ep = 4'($urandom_range(0, 8));
            rx_len = CNT_W'($urandom_range(0, 600));
            host_ack = ($urandom_range(0, 3) == 0);
            host_timeout = ($urandom_range(0, 4) == 0);
            bus_rst_done = ($urandom_range(0, 40) == 0);
            peer_hs = $urandom_range(0, 1);
            force_fs = ($urandom_range(0, 3) == 0);
            for (int i = 0; i < NUM_EP; i++)
                set_fifo(i, $urandom_range(0, 1100), $urandom_range(0, 1100));
            tick();
        end
        tok_valid = 0; host_ack = 0; host_timeout = 0; bus_rst_done = 0;
        tick();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule